// File: doc/BRIEF.md
# Receive FIFO Interrupt Controller

This block sits between a contactless-reader receive decoder and a host. The decoder hands it start-of-frame, byte, end-of-frame and error strobes. The block stores received bytes in a 12-entry FIFO and keeps an 8-bit IRQ status register that records why the host is being interrupted. It drives one interrupt line.

The interrupt policy follows the frame length. A frame of eight bytes or fewer interrupts the host once, when the frame ends. A longer frame interrupts early, as soon as its ninth byte is accepted, so the host can drain the FIFO before it fills. It interrupts again at end of frame. The host reads the status register to learn the cause. It reads the FIFO status register for the byte count, then pops bytes from the FIFO data address. Every read is a single-cycle strobe, and the read data is registered.

Top module: `rx_irq_ctrl`

## Requirements
- R1: After synchronous reset, the interrupt line and read data are 0. Both the IRQ status register and the FIFO status register read 00h.
- R2: A start-of-frame strobe sets status bit 6 (value 40h) and does not raise the interrupt line.
- R3: For a frame of 8 bytes or fewer, the interrupt line stays low until the end-of-frame strobe. That strobe sets status bit 0 (01h) and raises the interrupt line on the next clock.
- R4: When the ninth byte since start-of-frame arrives, status bit 5 (20h) is set and the interrupt line rises on the next clock.
- R5: The IRQ status register is read at address 0Ch. The read returns the accumulated bits, clears them all, and drops the interrupt line on the next clock.
- R6: A framing-error strobe sets status bit 3 (08h). A CRC-error strobe sets status bit 4 (10h). Neither raises the interrupt line on its own.
- R7: Each read of address 1Fh pops one byte from the 12-entry FIFO in arrival order.
- R8: A read of 1Fh while the FIFO is empty returns 00h and leaves the byte count unchanged.
- R9: Address 1Dh returns the FIFO status: the byte count in bits 3:0 and the overflow flag in bit 7. A byte that arrives while the FIFO is full is dropped and sets the overflow flag. The flag stays set until the FIFO status register is read.
- R10: A status event in the same cycle as a status read is not lost. The read returns the old value, and the new bit and interrupt remain afterwards.
- R11: A read of any other address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start-of-frame strobe from the decoder |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte value |
| eof_i | input | 1 | End-of-frame strobe |
| frame_err_i | input | 1 | Framing error strobe |
| crc_err_i | input | 1 | CRC error strobe |
| host_rd_i | input | 1 | Host read strobe, one cycle per access |
| host_addr_i | input | 5 | Host read address |
| host_rdata_o | output | 8 | Registered read data, valid the cycle after the strobe |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The interrupt policy is tested with three frames.

- A three-byte frame must keep the interrupt line low until end of frame.
- A ten-byte frame must raise the interrupt exactly at its ninth byte, not at the eighth. This shows that the threshold tracks frame position and not end of frame.
- A frame carrying both error strobes shows that each error lands in its own bit and that neither interrupts by itself.

A thirteen-byte burst fills the FIFO, which tells drop-and-flag apart from overwrite. Reads on an empty FIFO and a status read that collides with end of frame separate correct read-clear priority from lost events.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int BIT_DONE = 0;
  localparam int BIT_FERR = 3;
  localparam int BIT_CRC  = 4;
  localparam int BIT_HW   = 5;
  localparam int BIT_SOF  = 6;

  typedef struct packed {
    logic sof;
    logic hw;
    logic ferr;
    logic crc;
    logic done;
  } rxq_evt_t;
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 12,
  parameter int W = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  input  logic          ovf_clr,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          ovf
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          full, pop_ok, push_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   ovf_q <= 1'b0;
    else if (push && !push_ok) ovf_q <= 1'b1;
    else if (ovf_clr)          ovf_q <= 1'b0;
  end

  assign head  = mem[rptr];
  assign count = cnt_q;
  assign ovf   = ovf_q;

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT);
  // R9
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (ovf_q && cnt_q == FULL_CNT));
  // R8
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (cnt_q == '0));
endmodule

// File: rtl/rxq_frame_len.sv
module rxq_frame_len #(
  parameter int HW_BYTE = 9,
  localparam int LW = $clog2(HW_BYTE + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic sof,
  input  logic byte_vld,
  output logic hw_hit
);
  localparam logic [LW-1:0] HW_CNT  = LW'(HW_BYTE);
  localparam logic [LW-1:0] PRE_CNT = LW'(HW_BYTE - 1);

  logic [LW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst)                              len_q <= '0;
    else if (sof)                         len_q <= '0;
    else if (byte_vld && len_q != HW_CNT) len_q <= len_q + 1'b1;
  end

  assign hw_hit = byte_vld && !sof && (len_q == PRE_CNT);

  // R4
  hw_once_chk: assert property (@(posedge clk) disable iff (rst)
    hw_hit |=> !hw_hit);
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  rxq_evt_t     evt,
  input  logic         rd_clr,
  output logic [7:0]   status,
  output logic         irq
);
  logic [7:0] set_v;
  logic [7:0] st_q;
  logic       irq_q;
  logic       irq_evt;

  always_comb begin
    set_v           = '0;
    set_v[BIT_SOF]  = evt.sof;
    set_v[BIT_HW]   = evt.hw;
    set_v[BIT_CRC]  = evt.crc;
    set_v[BIT_FERR] = evt.ferr;
    set_v[BIT_DONE] = evt.done;
  end

  assign irq_evt = evt.hw || evt.done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= (rd_clr ? 8'h00 : st_q) | set_v;
      irq_q <= (rd_clr ? 1'b0 : irq_q) | irq_evt;
    end
  end

  assign status = st_q;
  assign irq    = irq_q;

  // R5
  clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && set_v == '0) |=> (st_q == '0 && !irq_q));
  // R2
  sof_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (evt.sof && !irq_q && !irq_evt) |=> (st_q[BIT_SOF] && !irq_q));
  // R10
  evt_kept_chk: assert property (@(posedge clk) disable iff (rst)
    irq_evt |=> irq_q);
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int HW_BYTE = 9,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] IRQ_ADDR   = 5'h0C,
  parameter logic [ADDR_W-1:0] FSTAT_ADDR = 5'h1D,
  parameter logic [ADDR_W-1:0] FDATA_ADDR = 5'h1F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              eof_i,
  input  logic              frame_err_i,
  input  logic              crc_err_i,
  input  logic              host_rd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              irq_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic              rd_irq, rd_fstat, rd_fdata;
  logic [DATA_W-1:0] head;
  logic [CW-1:0]     count;
  logic              empty, ovf, hw_hit;
  logic [7:0]        status;
  logic [DATA_W-1:0] fstat;
  logic [DATA_W-1:0] rdata_q;
  rxq_evt_t          evt;

  assign rd_irq   = host_rd_i && (host_addr_i == IRQ_ADDR);
  assign rd_fstat = host_rd_i && (host_addr_i == FSTAT_ADDR);
  assign rd_fdata = host_rd_i && (host_addr_i == FDATA_ADDR);

  rxq_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .push    (byte_vld_i),
    .din     (byte_i),
    .pop     (rd_fdata),
    .ovf_clr (rd_fstat),
    .head    (head),
    .count   (count),
    .empty   (empty),
    .ovf     (ovf)
  );

  rxq_frame_len #(.HW_BYTE(HW_BYTE)) u_len (
    .clk      (clk),
    .rst      (rst),
    .sof      (sof_i),
    .byte_vld (byte_vld_i),
    .hw_hit   (hw_hit)
  );

  always_comb begin
    evt.sof  = sof_i;
    evt.hw   = hw_hit;
    evt.ferr = frame_err_i;
    evt.crc  = crc_err_i;
    evt.done = eof_i;
  end

  rxq_status u_status (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .rd_clr (rd_irq),
    .status (status),
    .irq    (irq_o)
  );

  always_comb begin
    fstat            = '0;
    fstat[DATA_W-1]  = ovf;
    fstat[CW-1:0]    = count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (host_rd_i) begin
      if (rd_irq)        rdata_q <= status;
      else if (rd_fstat) rdata_q <= fstat;
      else if (rd_fdata) rdata_q <= empty ? '0 : head;
      else               rdata_q <= '0;
    end
  end

  assign host_rdata_o = rdata_q;

  // R8
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_fdata && empty) |=> (host_rdata_o == '0));
  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd_i && !rd_irq && !rd_fstat && !rd_fdata) |=> (host_rdata_o == '0));
endmodule

// File: tb/tb_rx_irq_ctrl.sv
module tb_rx_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sof_i = 0, byte_vld_i = 0, eof_i = 0, frame_err_i = 0, crc_err_i = 0;
  logic [7:0] byte_i = '0;
  logic       host_rd_i = 0;
  logic [4:0] host_addr_i = '0;
  logic [7:0] host_rdata_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  rx_irq_ctrl dut (
    .clk(clk), .rst(rst), .sof_i(sof_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .eof_i(eof_i), .frame_err_i(frame_err_i), .crc_err_i(crc_err_i),
    .host_rd_i(host_rd_i), .host_addr_i(host_addr_i),
    .host_rdata_o(host_rdata_o), .irq_o(irq_o)
  );

  localparam logic [2:0] OP_SOF = 0, OP_BYTE = 1, OP_EOF = 2, OP_RST = 3,
                         OP_RFS = 4, OP_RDAT = 5, OP_FERR = 6, OP_CRC = 7;

  // {req[3:0], op[2:0], data[7:0], expected rdata[7:0], expected irq}
  localparam int NV = 33;
  localparam logic [23:0] VEC [NV] = '{
    {4'd2, OP_SOF,  8'h00, 8'h00, 1'b0},  // R2
    {4'd3, OP_BYTE, 8'hA1, 8'h00, 1'b0},  // R3
    {4'd3, OP_BYTE, 8'hB2, 8'h00, 1'b0},  // R3
    {4'd3, OP_BYTE, 8'hC3, 8'h00, 1'b0},  // R3
    {4'd3, OP_EOF,  8'h00, 8'h00, 1'b1},  // R3
    {4'd5, OP_RST,  8'h00, 8'h41, 1'b0},  // R5
    {4'd9, OP_RFS,  8'h00, 8'h03, 1'b0},  // R9
    {4'd7, OP_RDAT, 8'h00, 8'hA1, 1'b0},  // R7
    {4'd7, OP_RDAT, 8'h00, 8'hB2, 1'b0},  // R7
    {4'd7, OP_RDAT, 8'h00, 8'hC3, 1'b0},  // R7
    {4'd8, OP_RDAT, 8'h00, 8'h00, 1'b0},  // R8
    {4'd8, OP_RFS,  8'h00, 8'h00, 1'b0},  // R8
    {4'd2, OP_SOF,  8'h00, 8'h00, 1'b0},  // R2
    {4'd4, OP_BYTE, 8'h10, 8'h00, 1'b0},  // R4
    {4'd4, OP_BYTE, 8'h11, 8'h00, 1'b0},  // R4
    {4'd4, OP_BYTE, 8'h12, 8'h00, 1'b0},  // R4
    {4'd4, OP_BYTE, 8'h13, 8'h00, 1'b0},  // R4
    {4'd4, OP_BYTE, 8'h14, 8'h00, 1'b0},  // R4
    {4'd4, OP_BYTE, 8'h15, 8'h00, 1'b0},  // R4
    {4'd4, OP_BYTE, 8'h16, 8'h00, 1'b0},  // R4
    {4'd4, OP_BYTE, 8'h17, 8'h00, 1'b0},  // R4 eighth byte, still low
    {4'd4, OP_BYTE, 8'h18, 8'h00, 1'b1},  // R4 ninth byte raises irq
    {4'd4, OP_BYTE, 8'h19, 8'h00, 1'b1},  // R4
    {4'd5, OP_RST,  8'h00, 8'h60, 1'b0},  // R5
    {4'd9, OP_RFS,  8'h00, 8'h0A, 1'b0},  // R9
    {4'd3, OP_EOF,  8'h00, 8'h00, 1'b1},  // R3
    {4'd5, OP_RST,  8'h00, 8'h01, 1'b0},  // R5
    {4'd7, OP_RDAT, 8'h00, 8'h10, 1'b0},  // R7
    {4'd2, OP_SOF,  8'h00, 8'h00, 1'b0},  // R2
    {4'd6, OP_FERR, 8'h00, 8'h00, 1'b0},  // R6
    {4'd6, OP_CRC,  8'h00, 8'h00, 1'b0},  // R6
    {4'd3, OP_EOF,  8'h00, 8'h00, 1'b1},  // R3
    {4'd6, OP_RST,  8'h00, 8'h59, 1'b0}   // R6
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [7:0] d,
                        input logic [7:0] exp, input logic exp_irq, input string tag);
    @(negedge clk);
    case (op)
      OP_SOF:  sof_i = 1;
      OP_BYTE: begin byte_vld_i = 1; byte_i = d; end
      OP_EOF:  eof_i = 1;
      OP_FERR: frame_err_i = 1;
      OP_CRC:  crc_err_i = 1;
      OP_RST:  begin host_rd_i = 1; host_addr_i = 5'h0C; end
      OP_RFS:  begin host_rd_i = 1; host_addr_i = 5'h1D; end
      default: begin host_rd_i = 1; host_addr_i = 5'h1F; end
    endcase
    @(negedge clk);
    sof_i = 0; byte_vld_i = 0; eof_i = 0; frame_err_i = 0; crc_err_i = 0; host_rd_i = 0;
    if (op >= OP_RST && op <= OP_RDAT) check({tag, " rdata"}, host_rdata_o, exp);
    check({tag, " irq"}, {7'd0, irq_o}, {7'd0, exp_irq});
  endtask

  task automatic read_at(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    host_rd_i = 1; host_addr_i = a;
    @(negedge clk);
    host_rd_i = 0;
    check(tag, host_rdata_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset irq", {7'd0, irq_o}, 8'h00);
    check("R1 reset rdata", host_rdata_o, 8'h00);
    for (int i = 0; i < NV; i++)
      run_op(VEC[i][19:17], VEC[i][16:9], VEC[i][8:1], VEC[i][0],
             $sformatf("R%0d vec%0d", VEC[i][23:20], i));

    // R1: reset with bytes still queued empties everything
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    check("R1 irq after reset", {7'd0, irq_o}, 8'h00);
    read_at(5'h1D, 8'h00, "R1 fifo status after reset");
    read_at(5'h0C, 8'h00, "R1 irq status after reset");

    // R9: thirteen bytes into a twelve-entry FIFO
    run_op(OP_SOF, 8'h00, 8'h00, 1'b0, "R2 sof");
    for (int i = 0; i < 13; i++)
      run_op(OP_BYTE, 8'h30 + 8'(i), 8'h00, (i >= 8), "R4 burst byte");
    read_at(5'h1D, 8'h8C, "R9 full with overflow");
    read_at(5'h1D, 8'h0C, "R9 overflow cleared by read");
    for (int i = 0; i < 12; i++)
      read_at(5'h1F, 8'h30 + 8'(i), "R7 fifo order");
    read_at(5'h1F, 8'h00, "R8 empty read");
    read_at(5'h1D, 8'h00, "R8 count stays zero");
    read_at(5'h0C, 8'h60, "R5 status after burst");

    // R10: status read collides with end of frame
    @(negedge clk);
    host_rd_i = 1; host_addr_i = 5'h0C; eof_i = 1;
    @(negedge clk);
    host_rd_i = 0; eof_i = 0;
    check("R10 old value returned", host_rdata_o, 8'h00);
    check("R10 irq kept", {7'd0, irq_o}, 8'h01);
    read_at(5'h0C, 8'h01, "R10 done bit kept");
    check("R5 irq dropped", {7'd0, irq_o}, 8'h00);

    read_at(5'h03, 8'h00, "R11 unmapped address");
    done_flag = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done_flag; c++) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule